// File: doc/BRIEF.md
# SPI memory address-width detector

This block is an SPI master sequencer that runs once before a boot loader starts reading a serial memory. It finds out how many address bytes the memory expects. The result is 8, 16, 24 or 32 bits. The probe works because the memory leaves its data line undriven until it has received a full address. A pull-up on the board then makes an undriven line read as 0xFF. The block drops chip select and sends a read opcode followed by zero bytes. After the second zero byte it inspects each received byte. The first byte that is not 0xFF fixes the width and is also handed out as the first data byte.

A probe is launched by a one-cycle `start` strobe while the block is idle. A strobe that arrives while a probe is running is ignored. The opcode is 0x03 or 0x0B, chosen by `opcode_fast`. The SCK rate comes from a divisor that is latched at start. Only a small set of divisor values is legal, and any other value falls back to the default. The outcome is reported by a one-cycle `done` pulse. The width, error flag and captured byte then stay unchanged until the next start. The outputs are plain status pins. There is no streaming handshake, because the block delivers one result per probe.

Top module: `spi_awidth_probe`

## Requirements
- R1: After reset, and while reset is held, spi_cs_n is 1, spi_sck is 0, done is 0, err is 0, addr_bits is 0 and first_byte is 0.
- R2: The first byte shifted out after spi_cs_n falls is the opcode. It is 0x03 when opcode_fast is 0 and 0x0B when opcode_fast is 1. opcode_fast is sampled at start.
- R3: The opcode is followed by 0x00 bytes. The byte received during the second 0x00 byte is the first one compared. If it is not 0xFF, addr_bits becomes 8.
- R4: While the compared byte is 0xFF, one more 0x00 byte is sent and the new byte is compared. A first non-0xFF byte after 3, 4 or 5 zero bytes gives addr_bits 16, 24 or 32.
- R5: If the byte received during the fifth zero byte is still 0xFF, the block sets err to 1, sets addr_bits to 0, pulses done and releases spi_cs_n. No sixth zero byte is sent.
- R6: At the decision, first_byte takes the compared byte: the first non-0xFF byte, or 0xFF on error.
- R7: Each SCK half period lasts baud_div system clocks when baud_div is one of 2, 4, 8, 16, 32, 64 or 133. The bit rate is therefore clk/(2*baud_div).
- R8: Any other baud_div value at start is reserved and is replaced by 133.
- R9: The SPI port uses mode 0. SCK is low whenever spi_cs_n is high. MOSI never changes while SCK is high. Bytes are shifted MSB first, and MISO is sampled on the rising edge.
- R10: spi_cs_n stays low from the opcode until the decision and then rises exactly once. The number of bytes clocked equals 1 plus the number of zero bytes the decision needed.
- R11: done is high for exactly one clock per probe. err, addr_bits and first_byte then hold until the next start. A start strobe during a probe has no effect on that probe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle strobe that launches a probe when idle |
| opcode_fast | input | 1 | 0 selects opcode 0x03, 1 selects 0x0B |
| baud_div | input | 8 | SCK half-period in clocks, latched at start |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the memory, MSB first |
| spi_miso | input | 1 | Serial data from the memory (pulled up when undriven) |
| spi_cs_n | output | 1 | Active-low chip select |
| done | output | 1 | One-cycle pulse when the decision is made |
| err | output | 1 | Set when no width was found |
| addr_bits | output | 6 | Detected address width: 8, 16, 24, 32, or 0 on error |
| first_byte | output | 8 | Byte that ended the probe |

## Verification
A miscounted zero-byte counter shows up at the ports in two ways. The byte count seen on MOSI is wrong, and so is addr_bits at the done pulse. Both are visible within one byte time of the faulty decision. A divider that latched the wrong value shows up in the very first SCK half period of the probe. The stub memory drives 0xFF until a set number of address bytes has passed. That lets each width, the error path and an all-zero data byte each appear in a run of their own.

// File: rtl/spi_probe_pkg.sv
package spi_probe_pkg;
  localparam int unsigned DIV_W = 8;
  localparam int unsigned AB_W = 6;
  localparam logic [DIV_W-1:0] DIV_DEFAULT = 8'd133;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_FAST = 8'h0B;
  localparam logic [7:0] IDLE_LINE = 8'hFF;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT} probe_state_t;

  function automatic logic div_legal(input logic [DIV_W-1:0] d);
    case (d)
      8'd2, 8'd4, 8'd8, 8'd16, 8'd32, 8'd64, 8'd133: div_legal = 1'b1;
      default: div_legal = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/spi_probe_clkdiv.sv
module spi_probe_clkdiv
  import spi_probe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  input  logic             run,
  output logic             tick
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIV_DEFAULT;
      cnt   <= '0;
    end else begin
      if (load) div_q <= div_legal(div_in) ? div_in : DIV_DEFAULT;
      if (!run || tick) cnt <= '0;
      else              cnt <= cnt + 1'b1;
    end
  end

  assert_div_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> div_legal(div_q));
  assert_tick_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/spi_probe_shifter.sv
module spi_probe_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       tick,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       busy,
  output logic       byte_done,
  output logic [7:0] rx_byte
);
  logic [7:0] tx_sr;
  logic [7:0] rx_sr;
  logic [2:0] bitn;

  assign mosi    = tx_sr[7];
  assign rx_byte = rx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr     <= '0;
      rx_sr     <= '0;
      bitn      <= '0;
      sck       <= 1'b0;
      busy      <= 1'b0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (load) begin
        tx_sr <= load_byte;
        bitn  <= '0;
        busy  <= 1'b1;
        sck   <= 1'b0;
      end else if (busy && tick) begin
        if (!sck) begin
          sck   <= 1'b1;
          rx_sr <= {rx_sr[6:0], miso};
        end else begin
          sck <= 1'b0;
          if (bitn == 3'd7) begin
            busy      <= 1'b0;
            byte_done <= 1'b1;
          end else begin
            bitn  <= bitn + 1'b1;
            tx_sr <= {tx_sr[6:0], 1'b0};
          end
        end
      end
    end
  end

  assert_mosi_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));
  assert_sck_low_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !sck || busy);
endmodule

// File: rtl/spi_probe_ctrl.sv
module spi_probe_ctrl
  import spi_probe_pkg::*;
#(
  parameter int unsigned MIN_ZEROS = 2,
  parameter int unsigned MAX_ZEROS = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            opcode_fast,
  input  logic            byte_done,
  input  logic [7:0]      rx_byte,
  output logic            accept,
  output logic            load,
  output logic [7:0]      load_byte,
  output logic            cs_n,
  output logic            done,
  output logic            err,
  output logic [AB_W-1:0] addr_bits,
  output logic [7:0]      first_byte
);
  localparam int unsigned CNT_W = $clog2(MAX_ZEROS + 1);

  probe_state_t     state;
  logic [CNT_W-1:0] zeros;
  logic [AB_W-1:0]  width_now;

  assign accept    = start && (state == ST_IDLE);
  assign width_now = AB_W'(zeros - 1'b1) << 3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      zeros      <= '0;
      load       <= 1'b0;
      load_byte  <= '0;
      cs_n       <= 1'b1;
      done       <= 1'b0;
      err        <= 1'b0;
      addr_bits  <= '0;
      first_byte <= '0;
    end else begin
      load <= 1'b0;
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state     <= ST_SHIFT;
            cs_n      <= 1'b0;
            load      <= 1'b1;
            load_byte <= opcode_fast ? OP_FAST : OP_READ;
            zeros     <= '0;
            err       <= 1'b0;
            addr_bits <= '0;
          end
        end
        default: begin
          if (byte_done) begin
            if (zeros < CNT_W'(MIN_ZEROS)) begin
              load      <= 1'b1;
              load_byte <= 8'h00;
              zeros     <= zeros + 1'b1;
            end else if (rx_byte != IDLE_LINE) begin
              state      <= ST_IDLE;
              cs_n       <= 1'b1;
              done       <= 1'b1;
              addr_bits  <= width_now;
              first_byte <= rx_byte;
            end else if (zeros == CNT_W'(MAX_ZEROS)) begin
              state      <= ST_IDLE;
              cs_n       <= 1'b1;
              done       <= 1'b1;
              err        <= 1'b1;
              first_byte <= rx_byte;
            end else begin
              load      <= 1'b1;
              load_byte <= 8'h00;
              zeros     <= zeros + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_cs_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> done);
  assert_width_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (addr_bits == 6'd8 || addr_bits == 6'd16 ||
                        addr_bits == 6'd24 || addr_bits == 6'd32));
  assert_err_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (addr_bits == '0 && first_byte == IDLE_LINE));
endmodule

// File: rtl/spi_awidth_probe.sv
module spi_awidth_probe
  import spi_probe_pkg::*;
#(
  parameter int unsigned MIN_ZEROS = 2,
  parameter int unsigned MAX_ZEROS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             opcode_fast,
  input  logic [DIV_W-1:0] baud_div,
  output logic             spi_sck,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic             spi_cs_n,
  output logic             done,
  output logic             err,
  output logic [AB_W-1:0]  addr_bits,
  output logic [7:0]       first_byte
);
  logic       accept;
  logic       load;
  logic [7:0] load_byte;
  logic       tick;
  logic       busy;
  logic       byte_done;
  logic [7:0] rx_byte;

  spi_probe_ctrl #(.MIN_ZEROS(MIN_ZEROS), .MAX_ZEROS(MAX_ZEROS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode_fast(opcode_fast),
    .byte_done(byte_done), .rx_byte(rx_byte), .accept(accept), .load(load),
    .load_byte(load_byte), .cs_n(spi_cs_n), .done(done), .err(err),
    .addr_bits(addr_bits), .first_byte(first_byte)
  );

  spi_probe_clkdiv u_div (
    .clk(clk), .rst_n(rst_n), .load(accept), .div_in(baud_div),
    .run(busy), .tick(tick)
  );

  spi_probe_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_byte(load_byte),
    .tick(tick), .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi),
    .busy(busy), .byte_done(byte_done), .rx_byte(rx_byte)
  );

  assert_sck_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);
  assert_shift_in_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !spi_cs_n);
endmodule

// File: tb/sim_spi_awidth_probe.sv
module sim_spi_awidth_probe;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic opcode_fast = 1'b0;
  logic [7:0] baud_div = 8'd2;
  logic spi_sck, spi_mosi, spi_cs_n, done, err;
  logic [5:0] addr_bits;
  logic [7:0] first_byte;
  logic miso_r = 1'b1;

  always #4 clk = ~clk;

  spi_awidth_probe u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode_fast(opcode_fast),
    .baud_div(baud_div), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(miso_r), .spi_cs_n(spi_cs_n), .done(done), .err(err),
    .addr_bits(addr_bits), .first_byte(first_byte)
  );

  int checks = 0;
  int errors = 0;

  // stub memory and monitors, all updated in this one block
  int n_addr = 1;
  logic [7:0] mem_data = 8'h01;
  logic mon_clr = 1'b0;
  int cyc = 0, bitcnt = 0, bytes_rx = 0, bad_zero = 0, mode_viol = 0;
  int done_cnt = 0, cs_rise = 0, rise_n = 0, t0 = 0, t1 = 0;
  logic [7:0] rx_sh = 8'h00, op_rx = 8'h00;
  logic sck_d = 1'b0, mosi_d = 1'b0, cs_d = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (mon_clr) begin
      bitcnt = 0; bytes_rx = 0; bad_zero = 0; mode_viol = 0; done_cnt = 0;
      cs_rise = 0; rise_n = 0; t0 = 0; t1 = 0; op_rx = 8'h00;
    end else begin
      if (spi_cs_n) begin
        bitcnt = 0;
        miso_r = 1'b1;
      end else begin
        if (spi_sck && !sck_d) begin
          rx_sh = {rx_sh[6:0], spi_mosi};
          bitcnt++;
          if (bitcnt % 8 == 0) begin
            bytes_rx++;
            if (bitcnt == 8) op_rx = rx_sh;
            else if (rx_sh != 8'h00) bad_zero++;
          end
          if (rise_n == 0) t0 = cyc;
          else if (rise_n == 1) t1 = cyc;
          rise_n++;
        end
        if (!spi_sck && sck_d)
          miso_r = (bitcnt / 8 >= 1 + n_addr) ? mem_data[7 - (bitcnt % 8)] : 1'b1;
      end
      if (spi_sck && sck_d && spi_mosi != mosi_d) mode_viol++;
      if (spi_cs_n && spi_sck) mode_viol++;
      if (done) done_cnt++;
      if (spi_cs_n && !cs_d) cs_rise++;
    end
    sck_d = spi_sck;
    mosi_d = spi_mosi;
    cs_d = spi_cs_n;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick1();
    @(negedge clk);
    #1;
  endtask

  typedef struct packed {
    logic       fast;
    logic [7:0] div;
    logic [3:0] naddr;
    logic [7:0] data;
    logic [5:0] exp_bits;
    logic       exp_err;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd2,   4'd1, 8'h01, 6'd8,  1'b0},
    '{1'b1, 8'd4,   4'd2, 8'h01, 6'd16, 1'b0},
    '{1'b0, 8'd8,   4'd3, 8'h5A, 6'd24, 1'b0},
    '{1'b1, 8'd2,   4'd4, 8'h01, 6'd32, 1'b0},
    '{1'b0, 8'd2,   4'd6, 8'h01, 6'd0,  1'b1},
    '{1'b0, 8'd3,   4'd1, 8'h01, 6'd8,  1'b0},
    '{1'b1, 8'd16,  4'd2, 8'h00, 6'd16, 1'b0},
    '{1'b0, 8'd64,  4'd1, 8'h01, 6'd8,  1'b0},
    '{1'b0, 8'd32,  4'd3, 8'h7E, 6'd24, 1'b0},
    '{1'b0, 8'd133, 4'd1, 8'h01, 6'd8,  1'b0},
    '{1'b0, 8'd0,   4'd2, 8'h01, 6'd16, 1'b0}
  };

  function automatic bit legal_div(input logic [7:0] d);
    return d == 2 || d == 4 || d == 8 || d == 16 || d == 32 || d == 64 || d == 133;
  endfunction

  task automatic run_vec(input vec_t v, input bit poke);
    int hp, exp_bytes, exp_first;
    bit got;
    logic [5:0] held_bits;
    hp = legal_div(v.div) ? int'(v.div) : 133;
    exp_bytes = v.exp_err ? 6 : int'(v.exp_bits) / 8 + 2;
    exp_first = v.exp_err ? 8'hFF : int'(v.data);
    mon_clr = 1'b1;
    opcode_fast = v.fast;
    baud_div = v.div;
    n_addr = int'(v.naddr);
    mem_data = v.data;
    tick1();
    mon_clr = 1'b0;
    start = 1'b1;
    tick1();
    start = 1'b0;
    got = 1'b0;
    for (int i = 0; i < 60000 && !got; i++) begin
      tick1();
      if (poke && i == 40) begin
        start = 1'b1;
        opcode_fast = !v.fast;
        baud_div = 8'd2;
      end else begin
        start = 1'b0;
      end
      if (done) got = 1'b1;
    end
    start = 1'b0;
    chk(got, "R11", "done seen", int'(got), 1);
    chk(addr_bits == v.exp_bits, v.exp_err ? "R5" : (v.exp_bits == 8 ? "R3" : "R4"),
        "addr_bits", int'(addr_bits), int'(v.exp_bits));
    chk(err == v.exp_err, "R5", "err", int'(err), int'(v.exp_err));
    chk(first_byte == exp_first[7:0], "R6", "first_byte", int'(first_byte), exp_first);
    chk(op_rx == (v.fast ? 8'h0B : 8'h03), "R2", "opcode", int'(op_rx),
        v.fast ? 8'h0B : 8'h03);
    chk(bad_zero == 0, "R3", "nonzero address byte", bad_zero, 0);
    chk(t1 - t0 == 2 * hp, legal_div(v.div) ? "R7" : "R8", "sck period",
        t1 - t0, 2 * hp);
    held_bits = addr_bits;
    repeat (30) tick1();
    chk(bytes_rx == exp_bytes, "R10", "bytes clocked", bytes_rx, exp_bytes);
    chk(spi_cs_n == 1'b1 && cs_rise == 1, "R10", "cs rises", cs_rise, 1);
    chk(mode_viol == 0, "R9", "mode 0 violations", mode_viol, 0);
    chk(done_cnt == 1, "R11", "done cycles", done_cnt, 1);
    chk(addr_bits == held_bits && err == v.exp_err, "R11", "held width",
        int'(addr_bits), int'(held_bits));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not end actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick1();
    chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1", "cs_n/sck in reset",
        int'({spi_cs_n, spi_sck}), 2);
    rst_n = 1'b1;
    repeat (2) tick1();
    chk(spi_cs_n == 1'b1 && spi_sck == 1'b0 && done == 1'b0, "R1", "idle pins",
        int'({spi_cs_n, spi_sck, done}), 4);
    chk(err == 1'b0 && addr_bits == 6'd0 && first_byte == 8'h00, "R1", "idle results",
        int'(addr_bits), 0);

    for (int k = 0; k < NV; k++) run_vec(VECS[k], 1'b0);

    // start during a running probe has no effect
    run_vec('{1'b0, 8'd8, 4'd2, 8'h33, 6'd16, 1'b0}, 1'b1);

    // reset in the middle of a probe
    opcode_fast = 1'b0;
    baud_div = 8'd8;
    n_addr = 3;
    start = 1'b1;
    tick1();
    start = 1'b0;
    repeat (200) tick1();
    chk(spi_cs_n == 1'b0, "R10", "cs low mid probe", int'(spi_cs_n), 0);
    rst_n = 1'b0;
    tick1();
    chk(spi_cs_n == 1'b1 && spi_sck == 1'b0 && done == 1'b0 && addr_bits == 6'd0,
        "R1", "reset mid probe", int'({spi_cs_n, spi_sck}), 2);
    rst_n = 1'b1;
    repeat (2) tick1();

    // a probe after reset still works
    run_vec('{1'b1, 8'd2, 4'd1, 8'h01, 6'd8, 1'b0}, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule